// File: doc/BRIEF.md
# Micro-Instruction Steered 8-bit Datapath

This block is the register-and-ALU half of a small microcoded processor. It holds an accumulator, a scratch register, a two-byte data pointer, an instruction register and a 16-bit program counter kept as a high and a low byte. An external sequencer presents one control word per clock. The word picks the memory address source, the byte placed on the data bus, the ALU operation, and the one register that the result bus loads. It also says whether the instruction register captures the data bus, whether the program counter steps, and whether memory is written.

The ALU takes the data bus on one side and the accumulator, as operand bus, on the other. It either passes the data bus through or adds the two. Its carry input can be forced high, so a pass-through turns into an increment of whatever byte sits on the data bus. Memory is a plain port: the address and the write data go out, and the read data for the address presented must be back within the same cycle. Writes take effect at the clock edge that ends a cycle with the write strobe high. The program counter, the data pointer or a page-zero address made from the data pointer's low byte can each drive the address.

Top module: `micro_datapath`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the program counter to 0x0000 and clears the accumulator, scratch, data pointer, instruction register and carry flag to zero.
- R2: With pc_inc high, the 16-bit program counter advances by one at the next edge, carrying from the low byte into the high byte (0x00FF becomes 0x0100, 0xFFFF becomes 0x0000).
- R3: mem_addr follows adr_sel combinationally: 0 and 3 give the program counter, 1 gives data-pointer-high:data-pointer-low, and 2 gives 0x00 above data-pointer-low.
- R4: With alu_add and carry_in both low, the result bus equals the data bus. dst_sel loads that result into exactly one register: 1 accumulator, 2 scratch, 3 data-pointer-high, 4 data-pointer-low, 5 program-counter-high. Codes 0, 6 and 7 load nothing.
- R5: With alu_add high, the result is (data bus + accumulator + carry_in) mod 256, and bit 8 of that sum is captured in carry_flag.
- R6: With alu_add low and carry_in high, the result is data bus + 1 mod 256, and carry_flag becomes 1 exactly when the data bus was 0xFF.
- R7: carry_flag holds its value in any cycle where alu_add and carry_in are both low.
- R8: src_sel chooses the data bus: 0 and 7 give mem_rdata, 1 the accumulator, 2 the scratch register, 3 data-pointer-high, 4 data-pointer-low, 5 program-counter-high, 6 program-counter-low.
- R9: mem_we equals mem_write in the same cycle, and mem_wdata always carries the accumulator. A store does not change the accumulator.
- R10: When dst_sel loads program-counter-high in the same cycle as pc_inc, the high byte takes the result bus and the low byte still increments. Any carry out of the low byte is discarded.
- R11: ir_load high captures the data bus into ir_out at the next edge. With ir_load low, ir_out holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adr_sel | input | 2 | Memory address source select |
| src_sel | input | 3 | Data bus source select |
| dst_sel | input | 3 | Result bus destination select |
| alu_add | input | 1 | 1 = add operand bus, 0 = pass data bus |
| carry_in | input | 1 | Adder carry input |
| ir_load | input | 1 | Load instruction register from data bus |
| pc_inc | input | 1 | Step the program counter |
| mem_write | input | 1 | Write the accumulator to memory |
| mem_rdata | input | 8 | Memory read data for the current address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| ir_out | output | 8 | Instruction register to the sequencer |
| carry_flag | output | 1 | Captured adder carry-out |

## Verification
Two functions can land in the same cycle and both touch the program counter: a result-bus load of its high byte and the counter's own step. The bench first walks the counter to 0x00FF so that the step would carry. It then issues one micro-instruction that loads the high byte from memory read data and also sets pc_inc. Reading the address with the program-counter source then has to show the loaded high byte over a low byte of 0x00, with no carry folded in. The same cycle-sharing shows up in opcode fetch, where the instruction register load and the counter step share one word and are judged separately.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef enum logic [1:0] {
    ADR_PC  = 2'd0,
    ADR_DP  = 2'd1,
    ADR_ZP  = 2'd2,
    ADR_PCX = 2'd3
  } adrSel_e;

  typedef enum logic [2:0] {
    SRC_MEM  = 3'd0,
    SRC_ACC  = 3'd1,
    SRC_TMP  = 3'd2,
    SRC_DPH  = 3'd3,
    SRC_DPL  = 3'd4,
    SRC_PCH  = 3'd5,
    SRC_PCL  = 3'd6,
    SRC_MEMX = 3'd7
  } srcSel_e;

  localparam logic [2:0] DST_ACC = 3'd1;
  localparam logic [2:0] DST_TMP = 3'd2;
  localparam logic [2:0] DST_DPH = 3'd3;
  localparam logic [2:0] DST_DPL = 3'd4;
  localparam logic [2:0] DST_PCH = 3'd5;

  typedef struct packed {
    logic    loadAcc;
    logic    loadTmp;
    logic    loadDph;
    logic    loadDpl;
    logic    loadPch;
    logic    loadIr;
    logic    pcStep;
    logic    useAdd;
    logic    forceCarry;
    logic    memWr;
    srcSel_e src;
    adrSel_e adr;
  } strobes_t;

endpackage

// File: rtl/dp_control.sv
module dp_control
  import mdp_pkg::*;
(
  input  logic [1:0] adrSel,
  input  logic [2:0] srcSel,
  input  logic [2:0] dstSel,
  input  logic       aluAdd,
  input  logic       carryIn,
  input  logic       irLoad,
  input  logic       pcInc,
  input  logic       memWrite,
  output strobes_t   strb
);

  always_comb begin
    strb            = '0;
    strb.adr        = adrSel_e'(adrSel);
    strb.src        = srcSel_e'(srcSel);
    strb.useAdd     = aluAdd;
    strb.forceCarry = carryIn;
    strb.loadIr     = irLoad;
    strb.pcStep     = pcInc;
    strb.memWr      = memWrite;
    case (dstSel)
      DST_ACC: strb.loadAcc = 1'b1;
      DST_TMP: strb.loadTmp = 1'b1;
      DST_DPH: strb.loadDph = 1'b1;
      DST_DPL: strb.loadDpl = 1'b1;
      DST_PCH: strb.loadPch = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dataBus,
  input  logic [DATA_W-1:0] operandBus,
  input  logic              useAdd,
  input  logic              forceCarry,
  output logic [DATA_W-1:0] resultBus,
  output logic              carryOut
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;
  logic [DATA_W-1:0] gatedOperand;

  assign gatedOperand = useAdd ? operandBus : '0;
  assign sum = {1'b0, dataBus} + {1'b0, gatedOperand} + {{DATA_W{1'b0}}, forceCarry};
  assign resultBus = sum[DATA_W-1:0];
  assign carryOut  = sum[DATA_W];

endmodule

// File: rtl/dp_core.sv
module dp_core
  import mdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  strobes_t            strb,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic                memWe,
  output logic [DATA_W-1:0]   irOut,
  output logic                carryFlag
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] acc, tmp, dph, dpl, pch, pcl, ir;
  logic              carry;
  logic [DATA_W-1:0] dataBus, resultBus;
  logic              aluCarry;
  logic [ADDR_W-1:0] pcFull, pcPlus;

  assign pcFull = {pch, pcl};
  assign pcPlus = pcFull + ADDR_W'(1);

  always_comb begin
    case (strb.src)
      SRC_ACC: dataBus = acc;
      SRC_TMP: dataBus = tmp;
      SRC_DPH: dataBus = dph;
      SRC_DPL: dataBus = dpl;
      SRC_PCH: dataBus = pch;
      SRC_PCL: dataBus = pcl;
      default: dataBus = memRdData;
    endcase
  end

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .dataBus    (dataBus),
    .operandBus (acc),
    .useAdd     (strb.useAdd),
    .forceCarry (strb.forceCarry),
    .resultBus  (resultBus),
    .carryOut   (aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      tmp   <= '0;
      dph   <= '0;
      dpl   <= '0;
      ir    <= '0;
      carry <= 1'b0;
    end else begin
      if (strb.loadAcc) acc <= resultBus;
      if (strb.loadTmp) tmp <= resultBus;
      if (strb.loadDph) dph <= resultBus;
      if (strb.loadDpl) dpl <= resultBus;
      if (strb.loadIr)  ir  <= dataBus;
      if (strb.useAdd || strb.forceCarry) carry <= aluCarry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pch <= '0;
      pcl <= '0;
    end else begin
      if (strb.pcStep) pcl <= pcPlus[DATA_W-1:0];
      if (strb.loadPch)     pch <= resultBus;
      else if (strb.pcStep) pch <= pcPlus[ADDR_W-1:DATA_W];
    end
  end

  always_comb begin
    case (strb.adr)
      ADR_DP:  memAddr = {dph, dpl};
      ADR_ZP:  memAddr = {{DATA_W{1'b0}}, dpl};
      default: memAddr = pcFull;
    endcase
  end

  assign memWrData = acc;
  assign memWe     = strb.memWr;
  assign irOut     = ir;
  assign carryFlag = carry;

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (pcFull == '0 && !carry));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pcStep && !strb.loadPch) |=> pcFull == $past(pcFull) + ADDR_W'(1));

  // R10
  pch_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadPch |=> (pch == $past(resultBus)) &&
      (pcl == ($past(strb.pcStep) ? $past(pcl) + DATA_W'(1) : $past(pcl))));

  // R7
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.useAdd || strb.forceCarry) |=> $stable(carry));

  // R5
  carry_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.useAdd || strb.forceCarry) |=> carry == $past(aluCarry));

  // R11
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.loadIr |=> $stable(ir));

endmodule

// File: rtl/micro_datapath.sv
module micro_datapath
  import mdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          adr_sel,
  input  logic [2:0]          src_sel,
  input  logic [2:0]          dst_sel,
  input  logic                alu_add,
  input  logic                carry_in,
  input  logic                ir_load,
  input  logic                pc_inc,
  input  logic                mem_write,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [DATA_W-1:0]   ir_out,
  output logic                carry_flag
);

  strobes_t strb;

  dp_control u_ctrl (
    .adrSel   (adr_sel),
    .srcSel   (src_sel),
    .dstSel   (dst_sel),
    .aluAdd   (alu_add),
    .carryIn  (carry_in),
    .irLoad   (ir_load),
    .pcInc    (pc_inc),
    .memWrite (mem_write),
    .strb     (strb)
  );

  dp_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .memRdData (mem_rdata),
    .memAddr   (mem_addr),
    .memWrData (mem_wdata),
    .memWe     (mem_we),
    .irOut     (ir_out),
    .carryFlag (carry_flag)
  );

endmodule

// File: tb/sim_micro_datapath.sv
module sim_micro_datapath;

  localparam logic [2:0] D_NONE = 3'd0, D_A = 3'd1, D_T = 3'd2, D_DPH = 3'd3,
                         D_DPL = 3'd4, D_PCH = 3'd5;
  localparam logic [2:0] S_MEM = 3'd0, S_A = 3'd1, S_T = 3'd2, S_DPH = 3'd3,
                         S_DPL = 3'd4, S_PCH = 3'd5, S_PCL = 3'd6, S_MEMX = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  adrSel = 2'd0;
  logic [2:0]  srcSel = 3'd0, dstSel = 3'd0;
  logic        aluAdd = 1'b0, carryIn = 1'b0, irLoad = 1'b0, pcInc = 1'b0, memWrite = 1'b0;
  logic [7:0]  rdByte = 8'h00;
  logic [15:0] memAddr;
  logic [7:0]  memWrData, irOut;
  logic        memWe, carryFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mA, mT, mDph, mDpl;
  logic [15:0] mPc;
  logic        mC;

  always #10 clk = ~clk;

  micro_datapath u0 (
    .clk(clk), .rst(rst), .adr_sel(adrSel), .src_sel(srcSel), .dst_sel(dstSel),
    .alu_add(aluAdd), .carry_in(carryIn), .ir_load(irLoad), .pc_inc(pcInc),
    .mem_write(memWrite), .mem_rdata(rdByte), .mem_addr(memAddr),
    .mem_wdata(memWrData), .mem_we(memWe), .ir_out(irOut), .carry_flag(carryFlag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nop();
    adrSel = 2'd0; srcSel = S_MEM; dstSel = D_NONE;
    aluAdd = 0; carryIn = 0; irLoad = 0; pcInc = 0; memWrite = 0;
  endtask

  task automatic uop(input logic [1:0] a, input logic [2:0] s, input logic [2:0] d,
                     input logic add, input logic ci, input logic ir,
                     input logic inc, input logic we);
    adrSel = a; srcSel = s; dstSel = d; aluAdd = add; carryIn = ci;
    irLoad = ir; pcInc = inc; memWrite = we;
    @(negedge clk);
    nop();
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    adrSel = a;
    #1;
    v = memAddr;
    adrSel = 2'd0;
    #1;
  endtask

  task automatic loadVia(input logic [2:0] d, input logic [7:0] v);
    rdByte = v;
    uop(2'd0, S_MEM, d, 0, 0, 0, 0, 0);
    case (d)
      D_A:   mA = v;
      D_T:   mT = v;
      D_DPH: mDph = v;
      D_DPL: mDpl = v;
      D_PCH: mPc[15:8] = v;
      default: ;
    endcase
  endtask

  task automatic stepPc(input string req);
    logic [15:0] got;
    uop(2'd0, S_MEM, D_NONE, 0, 0, 0, 1, 0);
    mPc = mPc + 16'd1;
    peek(2'd0, got);
    chk(req, got, mPc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [8:0]  sum;
    logic [7:0]  srcExp [8];
    nop();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mA = 0; mT = 0; mDph = 0; mDpl = 0; mPc = 0; mC = 0;

    // R1: reset state
    peek(2'd0, got); chk("R1 pc", got, 16'h0000);
    peek(2'd1, got); chk("R1 dp", got, 16'h0000);
    chk("R1 acc", {8'h00, memWrData}, 16'h0000);
    chk("R1 ir", {8'h00, irOut}, 16'h0000);
    chk("R1 carry", {15'h0, carryFlag}, 16'h0000);
    uop(2'd0, S_T, D_A, 0, 0, 0, 0, 0);
    chk("R1 tmp", {8'h00, memWrData}, 16'h0000);

    // R2 + R11: opcode fetch loads IR and steps PC in the same word
    rdByte = 8'hA9;
    uop(2'd0, S_MEM, D_NONE, 0, 0, 1, 1, 0);
    mPc = 16'h0001;
    chk("R11 ir load", {8'h00, irOut}, 16'h00A9);
    peek(2'd0, got); chk("R2 pc after fetch", got, 16'h0001);
    rdByte = 8'h3C;
    uop(2'd0, S_MEM, D_NONE, 0, 0, 0, 0, 0);
    chk("R11 ir hold", {8'h00, irOut}, 16'h00A9);

    // R2: sweep through low-byte carry
    for (int i = 0; i < 299; i++) stepPc("R2 pc step");
    loadVia(D_PCH, 8'hFF);
    peek(2'd0, got); chk("R4 pch load", got, mPc);
    for (int i = 0; i < 212; i++) stepPc("R2 pc wrap");
    chk("R2 pc wrapped to zero", mPc, 16'h0000);
    for (int i = 0; i < 255; i++) stepPc("R2 pc step");

    // R10: PCH load and PC step in the same cycle, PCL at 0xFF
    rdByte = 8'h42;
    uop(2'd0, S_MEM, D_PCH, 0, 0, 0, 1, 0);
    mPc = 16'h4200;
    peek(2'd0, got); chk("R10 pch load with step", got, 16'h4200);
    rdByte = 8'h17;
    uop(2'd0, S_MEM, D_PCH, 0, 0, 0, 1, 0);
    mPc = 16'h1701;
    peek(2'd0, got); chk("R10 pch load with step no wrap", got, 16'h1701);

    // R3: address sources
    loadVia(D_DPH, 8'h12);
    loadVia(D_DPL, 8'h34);
    peek(2'd1, got); chk("R3 data pointer", got, 16'h1234);
    peek(2'd2, got); chk("R3 page zero", got, 16'h0034);
    peek(2'd3, got); chk("R3 code 3 is pc", got, mPc);
    peek(2'd0, got); chk("R3 code 0 is pc", got, mPc);

    // R9: store A at DPH:DPL
    loadVia(D_A, 8'h5A);
    adrSel = 2'd1; memWrite = 1'b1;
    #1;
    chk("R9 we high", {15'h0, memWe}, 16'h0001);
    chk("R9 store addr", memAddr, 16'h1234);
    chk("R9 store data", {8'h00, memWrData}, 16'h005A);
    @(negedge clk);
    nop();
    #1;
    chk("R9 we low", {15'h0, memWe}, 16'h0000);
    chk("R9 acc kept", {8'h00, memWrData}, 16'h005A);

    // R8: source select sweep
    loadVia(D_A, 8'h11); loadVia(D_T, 8'h22);
    loadVia(D_DPH, 8'h33); loadVia(D_DPL, 8'h44);
    srcExp[1] = 8'h11; srcExp[2] = 8'h22; srcExp[3] = 8'h33; srcExp[4] = 8'h44;
    srcExp[5] = mPc[15:8]; srcExp[6] = mPc[7:0]; srcExp[0] = 8'h55; srcExp[7] = 8'h66;
    for (int c = 1; c < 9; c++) begin
      logic [2:0] code;
      code = 3'(c % 8);
      rdByte = srcExp[code];
      if (code == S_MEM || code == S_MEMX) rdByte = srcExp[code];
      else rdByte = 8'hEE;
      uop(2'd0, code, D_A, 0, 0, 0, 0, 0);
      mA = srcExp[code];
      chk($sformatf("R8 src code %0d", code), {8'h00, memWrData}, {8'h00, mA});
    end

    // R4: destination select sweep
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code;
      code = 3'(c);
      loadVia(code, 8'hC0 | {5'd0, code});
      chk($sformatf("R4 dst %0d acc", code), {8'h00, memWrData}, {8'h00, mA});
      peek(2'd1, got); chk($sformatf("R4 dst %0d dp", code), got, {mDph, mDpl});
      peek(2'd0, got); chk($sformatf("R4 dst %0d pc", code), got, mPc);
      uop(2'd0, S_T, D_A, 0, 0, 0, 0, 0);
      mA = mT;
      chk($sformatf("R4 dst %0d tmp", code), {8'h00, memWrData}, {8'h00, mT});
    end

    // R5: add sweep (zero-page form, sum into T)
    for (int i = 0; i < 18; i++) begin
      logic [7:0] a;
      a = (i == 17) ? 8'hFF : 8'(i * 15);
      for (int b = 0; b < 256; b++) begin
        loadVia(D_A, a);
        rdByte = 8'(b);
        uop(2'd2, S_MEM, D_T, 1, 0, 0, 0, 0);
        sum = {1'b0, a} + 9'(b);
        chk("R5 add carry", {15'h0, carryFlag}, {15'h0, sum[8]});
        uop(2'd0, S_T, D_A, 0, 0, 0, 0, 0);
        chk("R5 add sum", {8'h00, memWrData}, {8'h00, sum[7:0]});
        chk("R7 carry held on pass", {15'h0, carryFlag}, {15'h0, sum[8]});
      end
    end
    loadVia(D_A, 8'h7F);
    rdByte = 8'h80;
    uop(2'd0, S_MEM, D_A, 1, 1, 0, 0, 0);
    chk("R5 add with carry-in sum", {8'h00, memWrData}, 16'h0000);
    chk("R5 add with carry-in carry", {15'h0, carryFlag}, 16'h0001);

    // R6: increment sweep on DPL
    for (int v = 0; v < 256; v++) begin
      loadVia(D_DPL, 8'(v));
      uop(2'd0, S_DPL, D_DPL, 0, 1, 0, 0, 0);
      peek(2'd2, got);
      chk("R6 increment value", got, {8'h00, 8'(v + 1)});
      chk("R6 increment carry", {15'h0, carryFlag}, {15'h0, (v == 255)});
    end

    // R7: carry holds across pass operations, both polarities
    loadVia(D_T, 8'h00);
    chk("R7 carry hold 1", {15'h0, carryFlag}, 16'h0001);
    loadVia(D_A, 8'h01);
    rdByte = 8'h01;
    uop(2'd0, S_MEM, D_T, 1, 0, 0, 0, 0);
    chk("R5 small add clears carry", {15'h0, carryFlag}, 16'h0000);
    loadVia(D_T, 8'hFF);
    chk("R7 carry hold 0", {15'h0, carryFlag}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule